// File: doc/BRIEF.md
# General-Purpose Event Status and Routing Block

This block collects asynchronous event requests and turns them into power-management signals. It covers a bank of general-purpose inputs, an active-low power-management event pin, an internal bus-0 power-management request, two USB wake requests and a thermal-override flag. Each request is synchronised and edge-detected, then latched into a sticky 32-bit status register. A 32-bit enable register selects which latched events may act. Software reads both registers over a small register port and clears status bits by writing ones.

The routing outputs are levels driven from the latched state. In the working state (sleep code 0), an enabled pending event raises the system-control interrupt when the interrupt-select input is 1, and the management interrupt when it is 0. In any sleeping state (codes 1 to 7), an enabled pending event raises a wake request instead. The two power-management event sources do not wake the system from the soft-off state (code 5) when that state was forced by a power-button override or a power failure.

Top module: `gpeRouter`

## Requirements
- R1: After the active-low reset, the status and enable registers read all zeros, and wakeReq, sciOut and smiOut are low.
- R2: Status bit positions are fixed. Thermal override is bit 0, the event pin is bit 11, USB wake A is bit 12, bus-0 event is bit 13, USB wake B is bit 14, and general-purpose input n is bit 16+n. All other bits read 0 and cannot be set.
- R3: General-purpose status bit 16+n sets when input n's condition goes from false to true. The condition is gpiIsInput[n] AND (gpiPin[n] XOR gpiInvert[n]). The bit never sets while gpiIsInput[n] is 0.
- R4: A status bit stays set after its source goes away. Writing 1 to its position (regSel=0) clears it. Writing 0 leaves it unchanged.
- R5: If a hardware set and a software clear of the same status bit fall in the same cycle, the bit ends up set.
- R6: With regSel=1, the enable register is written and read directly. Only the bits that exist in R2 are kept, and enable bit 0 always reads 0.
- R7: In sleep code 0, sciOut = sciEnable AND (status AND enable is nonzero), and smiOut = NOT sciEnable AND the same term. Both are 0 in any other sleep code.
- R8: wakeReq is high only when the sleep code is not 0 and some enabled status bit is set. In sleep code 0 it is always 0.
- R9: When the sleep code is 5 and s5Forced is 1, bits 11 and 13 do not contribute to wakeReq. The other enabled bits still do. With s5Forced at 0, all enabled bits contribute.
- R10: The thermal-override bit never causes wakeReq, sciOut or smiOut.
- R11: Every event input is synchronised through two flops and edge-detected. A source asserted just after a clock edge shows in the status register after the third following rising edge, and not after the second. pmeReqN is active low. The other event inputs are active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Resume-domain reset, active low |
| gpiPin | input | NUM_GPI | General-purpose input pin levels |
| gpiIsInput | input | NUM_GPI | Per-input flag: pin is configured as an input |
| gpiInvert | input | NUM_GPI | Per-input polarity invert |
| pmeReqN | input | 1 | Power-management event pin, active low |
| bus0Pme | input | 1 | Internal bus-0 power-management request |
| usbWakeA | input | 1 | USB wake request A |
| usbWakeB | input | 1 | USB wake request B |
| thermOvr | input | 1 | Thermal override event |
| sleepState | input | 3 | Current sleep code, 0 = working |
| s5Forced | input | 1 | Soft-off entered by override or power failure |
| sciEnable | input | 1 | 1 selects sciOut, 0 selects smiOut |
| regSel | input | 1 | 0 = status register, 1 = enable register |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the selected register |
| wakeReq | output | 1 | Wake request level |
| sciOut | output | 1 | System-control interrupt level |
| smiOut | output | 1 | Management interrupt level |

## Verification
A source change lands in the status register on the third rising edge after it. The bench samples one negative edge before that point, where the bit must still be clear, and again at the edge where it must be set. Register writes take effect on the single edge inside the write task. The routing outputs and read data are combinational from the registers and the sleep inputs, so those checks sample 1 ns after the inputs change, with no clock in between. The set-over-clear case places the write strobe exactly on the third edge after the source rises.

// File: rtl/gpe_pkg.sv
package gpe_pkg;
  localparam int REG_W      = 32;
  localparam int BIT_THERM  = 0;
  localparam int BIT_PMEPIN = 11;
  localparam int BIT_USBA   = 12;
  localparam int BIT_BUS0   = 13;
  localparam int BIT_USBB   = 14;
  localparam int NUM_FIXED  = 5;

  typedef struct packed {
    logic [REG_W-1:0] setMask;
    logic [REG_W-1:0] clrMask;
    logic             enWrite;
    logic [REG_W-1:0] enData;
  } gpeStrobes_t;
endpackage

// File: rtl/gpeCtrl.sv
module gpeCtrl
  import gpe_pkg::*;
#(
  parameter int NUM_GPI     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_GPI-1:0] gpiPin,
  input  logic [NUM_GPI-1:0] gpiIsInput,
  input  logic [NUM_GPI-1:0] gpiInvert,
  input  logic               pmeReqN,
  input  logic               bus0Pme,
  input  logic               usbWakeA,
  input  logic               usbWakeB,
  input  logic               thermOvr,
  input  logic [2:0]         sleepState,
  input  logic               s5Forced,
  input  logic               sciEnable,
  input  logic               regSel,
  input  logic               wrEn,
  input  logic [REG_W-1:0]   wrData,
  input  logic [REG_W-1:0]   statusQ,
  input  logic [REG_W-1:0]   enableQ,
  output gpeStrobes_t        stb,
  output logic               wakeReq,
  output logic               sciOut,
  output logic               smiOut
);
  localparam int NUM_SRC = NUM_FIXED + NUM_GPI;
  localparam int GPI_LSB = REG_W - NUM_GPI;
  localparam logic [REG_W-1:0] GPI_BITS   = ((REG_W'(1) << NUM_GPI) - 1) << GPI_LSB;
  localparam logic [REG_W-1:0] PME_BITS   = (REG_W'(1) << BIT_PMEPIN) | (REG_W'(1) << BIT_BUS0);
  localparam logic [REG_W-1:0] FIXED_BITS = PME_BITS | (REG_W'(1) << BIT_USBA) | (REG_W'(1) << BIT_USBB);
  localparam logic [REG_W-1:0] EN_MASK    = GPI_BITS | FIXED_BITS;
  localparam logic [REG_W-1:0] STAT_MASK  = EN_MASK | (REG_W'(1) << BIT_THERM);

  logic [NUM_SRC-1:0] rawEv;
  logic [NUM_SRC-1:0] syncQ [SYNC_STAGES];
  logic [NUM_SRC-1:0] cond, prevQ, rise;

  assign rawEv = {gpiPin, thermOvr, usbWakeB, bus0Pme, usbWakeA, ~pmeReqN};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= rawEv;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= cond;
    end
  end

  assign cond[NUM_FIXED-1:0] = syncQ[SYNC_STAGES-1][NUM_FIXED-1:0];
  genvar g;
  generate
    for (g = 0; g < NUM_GPI; g++) begin : gGpi
      assign cond[NUM_FIXED+g] = gpiIsInput[g] & (syncQ[SYNC_STAGES-1][NUM_FIXED+g] ^ gpiInvert[g]);
    end
  endgenerate
  assign rise = cond & ~prevQ;

  always_comb begin
    stb = '0;
    stb.setMask[BIT_PMEPIN] = rise[0];
    stb.setMask[BIT_USBA]   = rise[1];
    stb.setMask[BIT_BUS0]   = rise[2];
    stb.setMask[BIT_USBB]   = rise[3];
    stb.setMask[BIT_THERM]  = rise[4];
    stb.setMask[GPI_LSB +: NUM_GPI] = rise[NUM_FIXED +: NUM_GPI];
    stb.clrMask = (wrEn && !regSel) ? (wrData & STAT_MASK) : '0;
    stb.enWrite = wrEn && regSel;
    stb.enData  = wrData & EN_MASK;
  end

  logic [REG_W-1:0] pendAll, wakeSrc;
  logic inS0, forcedOff;
  assign inS0      = (sleepState == 3'd0);
  assign forcedOff = s5Forced && (sleepState == 3'd5);
  assign pendAll   = statusQ & enableQ;
  assign wakeSrc   = forcedOff ? (pendAll & ~PME_BITS) : pendAll;
  assign wakeReq   = !inS0 && (|wakeSrc);
  assign sciOut    = inS0 && sciEnable && (|pendAll);
  assign smiOut    = inS0 && !sciEnable && (|pendAll);

  a_r8_no_wake_in_s0: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> (sleepState != 3'd0));
  a_r7_irq_only_s0: assert property (@(posedge clk) disable iff (!rstN)
    (sciOut || smiOut) |-> (sleepState == 3'd0));
  a_r7_irq_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(sciOut && smiOut));
  a_r10_therm_unrouted: assert property (@(posedge clk) disable iff (!rstN)
    !enableQ[BIT_THERM]);
endmodule

// File: rtl/gpeDatapath.sv
module gpeDatapath
  import gpe_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  gpeStrobes_t      stb,
  input  logic             regSel,
  output logic [REG_W-1:0] statusQ,
  output logic [REG_W-1:0] enableQ,
  output logic [REG_W-1:0] rdData
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
    end else begin
      statusQ <= (statusQ & ~stb.clrMask) | stb.setMask;
      if (stb.enWrite) enableQ <= stb.enData;
    end
  end

  assign rdData = regSel ? enableQ : statusQ;

  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    (stb.setMask != '0) |=> ((statusQ & $past(stb.setMask)) == $past(stb.setMask)));
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((statusQ & ($past(statusQ) & ~$past(stb.clrMask))) == ($past(statusQ) & ~$past(stb.clrMask))));
  a_r4_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.clrMask != '0) |=> ((statusQ & $past(stb.clrMask & ~stb.setMask)) == '0));
  a_r6_enable_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.enWrite |=> $stable(enableQ));
endmodule

// File: rtl/gpeRouter.sv
module gpeRouter
  import gpe_pkg::*;
#(
  parameter int NUM_GPI     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_GPI-1:0] gpiPin,
  input  logic [NUM_GPI-1:0] gpiIsInput,
  input  logic [NUM_GPI-1:0] gpiInvert,
  input  logic               pmeReqN,
  input  logic               bus0Pme,
  input  logic               usbWakeA,
  input  logic               usbWakeB,
  input  logic               thermOvr,
  input  logic [2:0]         sleepState,
  input  logic               s5Forced,
  input  logic               sciEnable,
  input  logic               regSel,
  input  logic               wrEn,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  output logic               wakeReq,
  output logic               sciOut,
  output logic               smiOut
);
  gpeStrobes_t      stb;
  logic [REG_W-1:0] statusQ, enableQ;

  gpeCtrl #(.NUM_GPI(NUM_GPI), .SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .gpiPin(gpiPin), .gpiIsInput(gpiIsInput),
    .gpiInvert(gpiInvert), .pmeReqN(pmeReqN), .bus0Pme(bus0Pme),
    .usbWakeA(usbWakeA), .usbWakeB(usbWakeB), .thermOvr(thermOvr),
    .sleepState(sleepState), .s5Forced(s5Forced), .sciEnable(sciEnable),
    .regSel(regSel), .wrEn(wrEn), .wrData(wrData), .statusQ(statusQ),
    .enableQ(enableQ), .stb(stb), .wakeReq(wakeReq), .sciOut(sciOut),
    .smiOut(smiOut)
  );

  gpeDatapath uData (
    .clk(clk), .rstN(rstN), .stb(stb), .regSel(regSel),
    .statusQ(statusQ), .enableQ(enableQ), .rdData(rdData)
  );
endmodule

// File: tb/sim_gpeRouter.sv
`timescale 1ns/1ps
module sim_gpeRouter;
  localparam int NG = 16;
  localparam logic [31:0] EN_MASK = 32'hFFFF_7800;

  logic clk = 0, rstN = 0;
  logic [NG-1:0] gpiPin = '0, gpiIsInput = '0, gpiInvert = '0;
  logic pmeReqN = 1, bus0Pme = 0, usbWakeA = 0, usbWakeB = 0, thermOvr = 0;
  logic [2:0] sleepState = 0;
  logic s5Forced = 0, sciEnable = 0, regSel = 0, wrEn = 0;
  logic [31:0] wrData = '0, rdData;
  logic wakeReq, sciOut, smiOut;
  int nChk = 0, nFail = 0;

  always #4 clk = ~clk;

  gpeRouter #(.NUM_GPI(NG), .SYNC_STAGES(2)) u0 (.*);

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    regSel = sel; wrData = d; wrEn = 1;
    @(negedge clk);
    wrEn = 0; wrData = '0;
  endtask

  task automatic rd(logic sel, output logic [31:0] d);
    regSel = sel; #1; d = rdData;
  endtask

  task automatic drive(int bitPos, logic on);
    case (bitPos)
      11: pmeReqN  = ~on;
      12: usbWakeA = on;
      13: bus0Pme  = on;
      14: usbWakeB = on;
      0:  thermOvr = on;
      default: begin gpiIsInput[bitPos-16] = 1; gpiInvert[bitPos-16] = 0; gpiPin[bitPos-16] = on; end
    endcase
  endtask

  task automatic latchOnly(int bitPos);
    wr(0, 32'hFFFF_FFFF);
    drive(bitPos, 1); step(4);
    drive(bitPos, 0); step(4);
    wr(0, 32'hFFFF_FFFF & ~(32'h1 << bitPos));
  endtask

  initial begin
    #(8 * 200000);
    nFail++; nChk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int fixedBits [5] = '{11, 12, 13, 14, 0};
    int routeBits [4] = '{11, 12, 13, 16};
    step(3); rstN = 1; step(1);
    // R1 reset state
    rd(0, v); chk("R1 status", v, 0);
    rd(1, v); chk("R1 enable", v, 0);
    chk("R1 outputs", {29'd0, wakeReq, sciOut, smiOut}, 0);
    // R6 enable register with masking
    step(1);
    wr(1, 32'hFFFF_FFFF); rd(1, v); chk("R6 all ones", v, EN_MASK);
    wr(1, 32'h0000_1234); rd(1, v); chk("R6 pattern", v, 32'h0000_1000);
    wr(1, 32'h0); rd(1, v); chk("R6 zero", v, 0);
    // R2 R11 R4 per fixed source
    foreach (fixedBits[k]) begin
      drive(fixedBits[k], 1);
      step(2); rd(0, v); chk("R11 not yet", v, 0);
      step(1); rd(0, v); chk("R2 R11 position", v, 32'h1 << fixedBits[k]);
      drive(fixedBits[k], 0); step(3);
      rd(0, v); chk("R4 sticky", v, 32'h1 << fixedBits[k]);
      wr(0, ~(32'h1 << fixedBits[k])); rd(0, v); chk("R4 write zero", v, 32'h1 << fixedBits[k]);
      wr(0, 32'h1 << fixedBits[k]); rd(0, v); chk("R4 clear", v, 0);
    end
    // R2 reserved bits cannot be set
    wr(0, 32'h0000_87FE); rd(0, v); chk("R2 reserved", v, 0);
    // R5 set beats clear in the same cycle
    usbWakeA = 1; step(2);
    regSel = 0; wrData = 32'h1 << 12; wrEn = 1; step(1); wrEn = 0; wrData = 0;
    rd(0, v); chk("R5 set wins", v, 32'h1 << 12);
    usbWakeA = 0; step(3); wr(0, 32'hFFFF_FFFF);
    // R3 sweep of every general-purpose input
    for (int n = 0; n < NG; n++)
      for (int cfg = 0; cfg < 4; cfg++) begin
        gpiIsInput[n] = cfg[0]; gpiInvert[n] = cfg[1]; gpiPin[n] = cfg[1];
        step(4); wr(0, 32'hFFFF_FFFF);
        gpiPin[n] = ~cfg[1]; step(3);
        rd(0, v); chk("R3 gpi sweep", v, cfg[0] ? (32'h1 << (16 + n)) : 32'h0);
        gpiPin[n] = 0; gpiInvert[n] = 0; gpiIsInput[n] = 0;
      end
    step(4); wr(0, 32'hFFFF_FFFF);
    // R7 R8 R9 routing sweep
    foreach (routeBits[k]) begin
      latchOnly(routeBits[k]);
      wr(1, 32'h0);
      for (int st = 0; st < 8; st++) begin
        sleepState = 3'(st); sciEnable = 1; #1;
        chk("R7 R8 enable gating", {29'd0, wakeReq, sciOut, smiOut}, 0);
      end
      wr(1, 32'hFFFF_FFFF);
      for (int st = 0; st < 8; st++)
        for (int se = 0; se < 2; se++)
          for (int fo = 0; fo < 2; fo++) begin
            logic isPme, inS0, expW;
            sleepState = 3'(st); sciEnable = se[0]; s5Forced = fo[0]; #1;
            isPme = (routeBits[k] == 11) || (routeBits[k] == 13);
            inS0 = (st == 0);
            expW = !inS0 && !(fo[0] && st == 5 && isPme);
            chk("R7 R8 R9 route", {29'd0, wakeReq, sciOut, smiOut},
                {29'd0, expW, inS0 && se[0], inS0 && !se[0]});
          end
      sleepState = 0; s5Forced = 0;
      wr(1, 32'h0); wr(0, 32'hFFFF_FFFF);
      gpiIsInput = '0;
    end
    // R10 thermal bit routes nowhere
    latchOnly(0);
    wr(1, 32'hFFFF_FFFF);
    rd(0, v); chk("R10 latched", v, 32'h1);
    for (int st = 0; st < 8; st++) begin
      sleepState = 3'(st); sciEnable = st[0]; #1;
      chk("R10 no route", {29'd0, wakeReq, sciOut, smiOut}, 0);
    end
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule